// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the device side of a small two-wire serial EEPROM. It samples the clock and data lines of the bus with the system clock and finds start and stop conditions. While a transaction is open it counts bus clocks, collects the select, address and data bits, and stores whole bytes in an internal byte array. On the data output it drives acknowledge bits and read data. In every other cycle it echoes the incoming data line, the way an undriven open-drain bus reads back.

A two-bit mode input selects the framing. Mode 0 is a compact legacy framing: the first byte holds a 7-bit word address with the read/write flag in its LSB, and there is no select byte. Mode 1 sends a select byte, then one address byte; select bits 3..1 supply address bits 10..8. Mode 2 sends a select byte, then two address bytes, high byte first. Mode 3 behaves as mode 2. Writes advance only within a page: four bytes in mode 0 and sixteen bytes otherwise. Reads advance through the whole address range. A side port lets a testbench load the array directly.

Top module: `twowire_eeprom`

## Requirements
- R1: An active-low reset closes any open transaction and clears the counter. After reset, the output echoes the synchronized data line, even during a cycle that would otherwise have been an acknowledge.
- R2: Data falling while the clock stays high opens a transaction and zeroes the cycle count. Data rising while the clock is high closes it. While no transaction is open, the output follows the data input.
- R3: In mode 0, the first byte (bit 0 = 0 for write) sets a 7-bit word address. Each following byte is stored MSB first at that address. Only the two low address bits then advance, so writes wrap inside an aligned 4-byte page.
- R4: In mode 0, with bit 0 of the first byte = 1, bytes are read from consecutive addresses. The 7-bit address wraps from 0x7F to 0x00.
- R5: The cycle counter rises by one on each clock rising edge while a transaction is open. The output is driven 0 during acknowledge cycles 9, 18 and 27. The legacy framing uses only cycle 9.
- R6: In mode 1, the select byte (bit 0 = 0) is followed by one address byte. Select bits 3..1 become address bits 10..8 when the address byte completes. Data occupies cycles 19 to 26.
- R7: In modes 1 and 2, a completed write byte advances only the four low address bits, so writes wrap inside an aligned 16-byte page.
- R8: In mode 2, the select byte is followed by a high and a low address byte. The last 13 address bits are kept, and the array is indexed by the low ADDR_W bits. Data occupies cycles 28 to 35.
- R9: In modes 1 and 2, a select byte with bit 0 = 1 reads from the current address. Each further byte advances the full address, crossing 16-byte boundaries.
- R10: A stop or start that arrives part-way through a data byte leaves the array unchanged.
- R11: A repeated start restarts the framing from cycle 0 and keeps the address. A write that sets an address can therefore be followed at once by a read from it.
- R12: During cycles that are neither acknowledge nor read data, the output echoes the data input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Framing select: 0 legacy, 1 one address byte, 2 or 3 two address bytes |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| sda_out | output | 1 | Data the device presents on the bus |
| pre_we | input | 1 | Direct array write strobe |
| pre_addr | input | ADDR_W | Direct array write address |
| pre_data | input | 8 | Direct array write data |

## Verification
The assertions assume that the mode input does not change while a transaction is open. Under that assumption, the counter bounds and page-wrap properties describe one framing at a time. They also assume that each bus level lasts long enough to pass the two-stage synchronizer. They further assume that clock and data never switch on the same system clock, except where a start or stop is intended. The stimulus changes the mode only after a stop. It holds every line level for six system clocks. It always moves the data line while the clock is low, except for the deliberate start and stop edges.

// File: rtl/twowire_eeprom.sv
module twowire_eeprom #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_out,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AW    = 13;
  localparam int CW    = 6;

  logic [1:0]    scl_sync, sda_sync;
  logic          scl_p, sda_p;
  logic          started;
  logic [CW-1:0] cyc;
  logic [AW-1:0] addr;
  logic          leg_rw;
  logic [7:0]    slave;
  logic [7:0]    data_sr;
  logic [7:0]    mem [DEPTH];

  wire scl_s = scl_sync[1];
  wire sda_s = sda_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  wire start_ev = scl_p & scl_s & sda_p & ~sda_s;
  wire stop_ev  = scl_p & scl_s & ~sda_p & sda_s;
  wire rise_ev  = started & ~scl_p & scl_s;
  wire fall_ev  = started & scl_p & ~scl_s;

  wire legacy   = (mode == 2'd0);
  wire one_byte = (mode == 2'd1);
  wire rd_mode  = legacy ? leg_rw : slave[0];

  wire [CW-1:0] dfirst  = legacy ? CW'(10) : one_byte ? CW'(19) : CW'(28);
  wire [CW-1:0] dlast   = dfirst + CW'(7);
  wire [CW-1:0] cyc_inc = cyc + CW'(1);
  wire ack_cyc = (cyc == CW'(9)) ||
                 (!legacy && (cyc == CW'(18) || cyc == CW'(27)));
  wire sel_cyc = (cyc >= CW'(1)) && (cyc <= CW'(8));

  wire data_bit  = fall_ev && !sel_cyc && !ack_cyc && !rd_mode && (cyc >= dfirst);
  wire addr_bit  = fall_ev && !sel_cyc && !ack_cyc && !rd_mode &&
                   (cyc >= CW'(10)) && (cyc < dfirst);
  wire commit    = data_bit && (cyc == dlast);
  wire [7:0] wbyte = {data_sr[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      cyc     <= '0;
      addr    <= '0;
      leg_rw  <= 1'b0;
      slave   <= '0;
      data_sr <= '0;
    end else if (start_ev) begin
      started <= 1'b1;
      cyc     <= '0;
      data_sr <= '0;
    end else if (stop_ev) begin
      started <= 1'b0;
      data_sr <= '0;
    end else if (rise_ev) begin
      if (cyc_inc == CW'(18) && (legacy || rd_mode)) begin
        cyc <= CW'(9);
        if (rd_mode)
          addr <= legacy ? {6'd0, addr[6:0] + 7'd1} : addr + AW'(1);
      end else if (cyc_inc == CW'(27) && one_byte) begin
        cyc <= CW'(18);
      end else if (cyc_inc == CW'(36)) begin
        cyc <= CW'(27);
      end else begin
        cyc <= cyc_inc;
      end
    end else if (fall_ev) begin
      if (sel_cyc) begin
        if (legacy) begin
          {addr[6:0], leg_rw} <= {addr[5:0], leg_rw, sda_s};
          addr[AW-1:7] <= '0;
        end else begin
          slave <= {slave[6:0], sda_s};
        end
      end else if (data_bit) begin
        data_sr <= wbyte;
        if (commit)
          addr <= legacy ? {addr[AW-1:2], addr[1:0] + 2'd1}
                         : {addr[AW-1:4], addr[3:0] + 4'd1};
      end else if (addr_bit) begin
        if (one_byte)
          addr <= (cyc == CW'(17)) ? {2'b00, slave[3:1], addr[6:0], sda_s}
                                   : {5'd0, addr[6:0], sda_s};
        else
          addr <= {addr[AW-2:0], sda_s};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pre_we)
      mem[pre_addr] <= pre_data;
    if (commit)
      mem[addr[ADDR_W-1:0]] <= wbyte;
  end

  wire [7:0]    rd_byte = mem[addr[ADDR_W-1:0]];
  wire [CW-1:0] shift   = CW'(17) - cyc;
  wire rd_cyc = rd_mode && (cyc >= CW'(10)) && (cyc <= CW'(17));

  assign sda_out = !started ? sda_s :
                   ack_cyc  ? 1'b0  :
                   rd_cyc   ? rd_byte[shift[2:0]] : sda_s;
endmodule

module twowire_eeprom_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        started,
  input logic [5:0]  cyc,
  input logic [12:0] addr,
  input logic        rd_mode,
  input logic        scl_s,
  input logic        scl_p,
  input logic        sda_s,
  input logic        sda_p
);
  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_p && scl_s && sda_p && !sda_s) |=> (started && cyc == 6'd0));

  assert_stop_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_p && scl_s && !sda_p && sda_s) |=> !started);

  assert_cyc_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !scl_p && scl_s) |=> (cyc != $past(cyc)));

  assert_cyc_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_s == scl_p) && !(scl_s && sda_p && !sda_s)) |=> $stable(cyc));

  assert_legacy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode == 2'd0) |-> (cyc <= 6'd17));

  assert_one_byte_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode == 2'd1) |-> (cyc <= 6'd26));

  assert_legacy_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode == 2'd0 && !rd_mode && cyc >= 6'd10) |=> $stable(addr[6:2]));

  assert_dev_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode != 2'd0 && !rd_mode &&
     cyc >= ((mode == 2'd1) ? 6'd19 : 6'd28)) |=> $stable(addr[12:4]));
endmodule

bind twowire_eeprom twowire_eeprom_chk chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .started(started), .cyc(cyc),
  .addr(addr), .rd_mode(rd_mode), .scl_s(scl_s), .scl_p(scl_p),
  .sda_s(sda_s), .sda_p(sda_p)
);

// File: tb/twowire_eeprom_test.sv
`timescale 1ns/1ps
module twowire_eeprom_test;
  localparam int AW = 11;
  localparam int HP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          scl = 1'b1;
  logic          sda = 1'b1;
  logic          sda_out;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0]    pre_data = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  twowire_eeprom #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .scl_in(scl), .sda_in(sda),
    .sda_out(sda_out), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  // {mode, address, data}: written then read back in the same framing
  localparam logic [22:0] VEC [6] = '{
    {2'd0, 13'h0005, 8'h3C},
    {2'd0, 13'h007F, 8'hA5},
    {2'd1, 13'h02F3, 8'h5A},
    {2'd1, 13'h07FE, 8'hC3},
    {2'd2, 13'h0456, 8'h96},
    {2'd2, 13'h1001, 8'h0F}
  };

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda = 1'b1; hold(HP);
    scl = 1'b1; hold(HP);
    sda = 1'b0; hold(HP);
    scl = 1'b0; hold(HP);
  endtask

  task automatic bus_stop();
    sda = 1'b0; hold(HP);
    scl = 1'b1; hold(HP);
    sda = 1'b1; hold(HP);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda = b; hold(HP);
    scl = 1'b1; hold(HP);
    r = sda_out;
    scl = 1'b0; hold(HP);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(v[i], r);
      check("R12 echo", {7'd0, r}, {7'd0, v[i]});
    end
    clk_bit(1'b1, r);
    check("R5 ack", {7'd0, r}, 8'd0);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(1'b0, r);
  endtask

  task automatic dev_addr(input logic [1:0] m, input logic [12:0] a);
    bus_start();
    if (m == 2'd1) begin
      send_byte({4'hA, a[10:8], 1'b0});
      send_byte(a[7:0]);
    end else begin
      send_byte(8'hA0);
      send_byte({3'd0, a[12:8]});
      send_byte(a[7:0]);
    end
  endtask

  task automatic write_bytes(input logic [1:0] m, input logic [12:0] a,
                             input int n, input logic [23:0] dat);
    mode = m;
    if (m == 2'd0) begin
      bus_start();
      send_byte({a[6:0], 1'b0});
    end else begin
      dev_addr(m, a);
    end
    for (int k = 0; k < n; k++) send_byte(dat[23-8*k -: 8]);
    bus_stop();
  endtask

  task automatic read_bytes(input logic [1:0] m, input logic [12:0] a,
                            input int n, output logic [39:0] got);
    logic [7:0] v;
    got = '0;
    mode = m;
    if (m == 2'd0) begin
      bus_start();
      send_byte({a[6:0], 1'b1});
    end else begin
      dev_addr(m, a);
      bus_start();
      send_byte(8'hA1);
    end
    for (int k = 0; k < n; k++) begin
      recv_byte(v);
      got[39-8*k -: 8] = v;
    end
    bus_stop();
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [7:0] d);
    pre_addr = a; pre_data = d; pre_we = 1'b1;
    hold(1);
    pre_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [39:0] got;
    logic r;
    hold(4);
    rst_n = 1'b1;
    hold(HP);

    // R1 / R2: idle after reset echoes the data line
    check("R1 idle high", {7'd0, sda_out}, 8'd1);
    scl = 1'b0; hold(HP);
    sda = 1'b0; hold(HP);
    check("R2 idle echo low", {7'd0, sda_out}, 8'd0);
    sda = 1'b1; hold(HP);
    scl = 1'b1; hold(HP);

    // Table walk: write one byte, read it back (R3, R6, R8, R9, R11)
    for (int i = 0; i < 6; i++) begin
      logic [1:0]  m;
      logic [12:0] a;
      logic [7:0]  d;
      m = VEC[i][22:21];
      a = VEC[i][20:8];
      d = VEC[i][7:0];
      write_bytes(m, a, 1, {d, 16'd0});
      read_bytes(m, a, 1, got);
      check(m == 2'd0 ? "R3 legacy byte" : m == 2'd1 ? "R6 one-address byte" : "R8 two-address byte",
            got[39:32], d);
    end

    // R3 / R4: legacy 4-byte page wrap, then sequential read
    for (int k = 16; k <= 20; k++) preload(AW'(k), 8'h00);
    write_bytes(2'd0, 13'h0012, 3, 24'h112233);
    sda = 1'b1; scl = 1'b0; hold(HP);
    check("R2 echo after stop", {7'd0, sda_out}, 8'd1);
    sda = 1'b0; hold(HP);
    check("R2 echo after stop low", {7'd0, sda_out}, 8'd0);
    sda = 1'b1; hold(HP);
    scl = 1'b1; hold(HP);
    read_bytes(2'd0, 13'h0010, 5, got);
    check("R3 page wrap to base", got[39:32], 8'h33);
    check("R4 untouched next", got[31:24], 8'h00);
    check("R3 first write", got[23:16], 8'h11);
    check("R3 second write", got[15:8], 8'h22);
    check("R3 no spill past page", got[7:0], 8'h00);

    // R4: legacy read wraps 0x7F -> 0x00
    preload(AW'(8'h7F), 8'hE1);
    preload(AW'(0), 8'h1E);
    read_bytes(2'd0, 13'h007F, 2, got);
    check("R4 read at 7F", got[39:32], 8'hE1);
    check("R4 wrap to 00", got[31:24], 8'h1E);

    // R7 / R9: one-address mode, 16-byte page wrap and full-increment reads
    for (int k = 0; k < 16; k++) preload(AW'(11'h3F0 + k), 8'h00);
    preload(AW'(11'h400), 8'h77);
    write_bytes(2'd1, 13'h03FE, 3, 24'hAABBCC);
    read_bytes(2'd1, 13'h03FE, 3, got);
    check("R9 read 3FE", got[39:32], 8'hAA);
    check("R9 read 3FF", got[31:24], 8'hBB);
    check("R9 cross to 400", got[23:16], 8'h77);
    read_bytes(2'd1, 13'h03F0, 1, got);
    check("R7 page wrap 3F0", got[39:32], 8'hCC);

    // R7 / R8: two-address mode page wrap
    write_bytes(2'd2, 13'h0ABF, 2, 24'h5AA500);
    read_bytes(2'd2, 13'h0ABF, 1, got);
    check("R8 write at ABF", got[39:32], 8'h5A);
    read_bytes(2'd2, 13'h0AB0, 1, got);
    check("R7 two-address page wrap", got[39:32], 8'hA5);

    // R10: stop inside a data byte
    preload(AW'(11'h050), 8'h5D);
    mode = 2'd2;
    dev_addr(2'd2, 13'h0050);
    for (int k = 0; k < 4; k++) clk_bit(1'b0, r);
    bus_stop();
    read_bytes(2'd2, 13'h0050, 1, got);
    check("R10 stop mid byte", got[39:32], 8'h5D);

    // R10 / R11: repeated start inside a data byte, then current-address read
    dev_addr(2'd2, 13'h0050);
    for (int k = 0; k < 4; k++) clk_bit(1'b1, r);
    bus_start();
    send_byte(8'hA1);
    recv_byte(got[39:32]);
    bus_stop();
    check("R11 restart keeps address", got[39:32], 8'h5D);

    // R1: reset inside a transaction closes it
    mode = 2'd0;
    bus_start();
    for (int i = 7; i >= 0; i--) clk_bit(i[0], r);
    rst_n = 1'b0; hold(3);
    rst_n = 1'b1; hold(HP);
    clk_bit(1'b1, r);
    check("R1 reset closes transaction", {7'd0, r}, 8'd1);
    sda = 1'b1; hold(HP);
    scl = 1'b1; hold(HP);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule